// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks the chain of extended capability headers kept in a 4 KB configuration space. The chain always begins at byte offset 0x100. Each 32-bit header holds a capability ID, a version and a pointer to the next header. The walker reads the headers one at a time through a synchronous memory port that returns data one cycle after the read strobe. A search returns the offset of the first header whose ID matches, together with the offset of the header visited just before it.

An append command adds a new capability to the end of the chain. If the new capability sits at 0x100, the walker writes only its header. At any other offset it first finds the tail of the chain. It does this with a search ID that cannot match any header. It then rewrites the tail's next field to point at the new offset, and writes the new header with a zero next field.

Broken chains are reported through an error flag rather than followed. This covers misaligned or out-of-window pointers and chains that never end. Append parameters that do not fit the configuration space are also reported as errors.

Top module: `ecap_walker`

## Requirements
- R1: After reset, busy_o, done_o, found_o, err_o, mem_re_o and mem_we_o are all 0.
- R2: A start_i pulse while idle begins an operation. done_o then pulses for exactly one cycle, and found_o, err_o, next_o and prev_o keep their values until the next start.
- R3: A header holds the ID in bits 15:0, the version in bits 19:16 and the next offset in bits 31:20. A next offset of 0 ends the chain.
- R4: If the header at 0x100 reads as all zeros, a search ends immediately with found_o=0, next_o=0 and prev_o=0, whatever the search ID is, including ID 0.
- R5: When a header's ID equals sid_i, the search ends with found_o=1, next_o equal to that header's offset, and prev_o equal to the offset visited before it (0 for the head). A match wins over a zero next field in the same header.
- R6: When the chain ends with no match, found_o=0, next_o=0 and prev_o is the tail's offset. A sid_i with bit 16 set never matches.
- R7: A next pointer whose low two bits are not zero, that is below 0x100, or that is above 0xFF8 ends the walk with err_o=1, found_o=0 and next_o=0.
- R8: A walk that has examined 1024 headers without ending stops with err_o=1.
- R9: An append at offset 0x100 performs exactly one write: {12'h000, version, ID} at 0x100.
- R10: An append at any other offset performs two writes. First, the tail header is rewritten with only bits 31:20 changed to the new offset. Second, {12'h000, version, ID} is written at the new offset. prev_o then reports the old tail. An append at any offset other than 0x100 into an empty chain is an error with no write.
- R11: An append with app_size_i below 8, with offset plus size above 0x1000, with an offset below 0x100 or with an offset that is not a multiple of 4 sets err_o and writes nothing.
- R12: mem_rdata_i is used in the cycle after mem_re_o, and mem_re_o and mem_we_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation (only while idle) |
| append_i | input | 1 | 0: search, 1: append |
| sid_i | input | 17 | Search ID; bit 16 set never matches |
| app_off_i | input | 12 | Byte offset of the capability to append |
| app_size_i | input | 13 | Size in bytes of the capability to append |
| app_id_i | input | 16 | ID of the capability to append |
| app_ver_i | input | 4 | Version of the capability to append |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Search matched |
| err_o | output | 1 | Operation ended in error |
| next_o | output | 12 | Offset of the match, or 0 |
| prev_o | output | 12 | Offset visited before the result |
| mem_re_o | output | 1 | Read strobe |
| mem_we_o | output | 1 | Write strobe |
| mem_addr_o | output | 12 | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after mem_re_o |

## Verification
A single header check can hit several exit conditions at once. An all-zero head is both an empty chain and a header with ID 0. A tail header can also carry the searched ID. Both cases are provoked directly: a search for ID 0 on an empty chain must report not-found with prev 0, and a search for the tail's own ID must report a match with the preceding offset rather than an end-of-chain. The append path combines the hidden tail search with two writes, and is judged by reading back the memory model and counting write strobes.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int ID_W  = 16;
  localparam int VER_W = 4;
  localparam int NXT_W = 12;

  typedef struct packed {
    logic [NXT_W-1:0] nxt;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } ecap_hdr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CHK, S_PATCH, S_NEW
  } walk_st_e;
endpackage

// File: rtl/ecap_hdr_dec.sv
module ecap_hdr_dec
  import ecap_pkg::*;
#(
  parameter int BASE_OFF  = 256,
  parameter int LIMIT_OFF = 4088
) (
  input  ecap_hdr_t     hdr_i,
  input  logic [ID_W:0] sid_i,
  output logic          hit_o,
  output logic          tail_o,
  output logic          blank_o,
  output logic          ptr_bad_o
);
  localparam logic [NXT_W-1:0] BASE_L  = NXT_W'(BASE_OFF);
  localparam logic [NXT_W-1:0] LIMIT_L = NXT_W'(LIMIT_OFF);

  assign hit_o     = ({1'b0, hdr_i.id} == sid_i);
  assign tail_o    = (hdr_i.nxt == '0);
  assign blank_o   = (hdr_i == '0);
  assign ptr_bad_o = (hdr_i.nxt[1:0] != 2'b00) || (hdr_i.nxt < BASE_L) ||
                     (hdr_i.nxt > LIMIT_L);
endmodule

// File: rtl/ecap_app_chk.sv
module ecap_app_chk #(
  parameter int OFF_W     = 12,
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int MIN_SIZE  = 8
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W:0]   size_i,
  output logic             bad_o
);
  localparam int SUM_W = OFF_W + 2;
  logic [SUM_W-1:0] end_w;

  assign end_w = SUM_W'(off_i) + SUM_W'(size_i);
  assign bad_o = (size_i < (OFF_W+1)'(MIN_SIZE)) ||
                 (end_w > SUM_W'(CFG_BYTES)) ||
                 (off_i < OFF_W'(BASE_OFF)) ||
                 (off_i[1:0] != 2'b00);
endmodule

// File: rtl/ecap_guard.sv
module ecap_guard #(
  parameter int MAX_HDRS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(MAX_HDRS + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(MAX_HDRS - 1));

  p_guard_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_HDRS));
  p_guard_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !(cnt_q == CNT_W'(MAX_HDRS)));
endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
  import ecap_pkg::*;
#(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int MAX_HDRS  = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              append_i,
  input  logic [ID_W:0]     sid_i,
  input  logic [NXT_W-1:0]  app_off_i,
  input  logic [NXT_W:0]    app_size_i,
  input  logic [ID_W-1:0]   app_id_i,
  input  logic [VER_W-1:0]  app_ver_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic              err_o,
  output logic [NXT_W-1:0]  next_o,
  output logic [NXT_W-1:0]  prev_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [NXT_W-1:0]  mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);
  localparam int LIMIT_OFF = CFG_BYTES - 8;
  localparam logic [NXT_W-1:0] BASE_L = NXT_W'(BASE_OFF);

  walk_st_e          st_q;
  logic [NXT_W-1:0]  cur_q, back_q, app_off_q, res_q, prev_q;
  logic [ID_W:0]     sid_q;
  logic [ID_W-1:0]   app_id_q;
  logic [VER_W-1:0]  app_ver_q;
  ecap_hdr_t         hdr_q, rhdr;
  logic              app_q, found_q, err_q, done_q;
  logic              hit, tail, blank, ptr_bad, app_bad, g_last, follow;

  assign rhdr = ecap_hdr_t'(mem_rdata_i);

  ecap_hdr_dec #(.BASE_OFF(BASE_OFF), .LIMIT_OFF(LIMIT_OFF)) u_dec (
    .hdr_i(rhdr), .sid_i(sid_q), .hit_o(hit), .tail_o(tail),
    .blank_o(blank), .ptr_bad_o(ptr_bad)
  );

  ecap_app_chk #(.OFF_W(NXT_W), .CFG_BYTES(CFG_BYTES), .BASE_OFF(BASE_OFF)) u_app (
    .off_i(app_off_i), .size_i(app_size_i), .bad_o(app_bad)
  );

  // follow the pointer only when no exit condition applies
  assign follow = (st_q == S_CHK) && !(cur_q == BASE_L && blank) && !hit &&
                  !tail && !ptr_bad && !g_last;

  ecap_guard #(.MAX_HDRS(MAX_HDRS)) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(st_q == S_IDLE),
    .inc_i(follow), .last_o(g_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; cur_q <= '0; back_q <= '0; app_off_q <= '0;
      res_q <= '0; prev_q <= '0; sid_q <= '0; app_id_q <= '0;
      app_ver_q <= '0; hdr_q <= '0; app_q <= 1'b0; found_q <= 1'b0;
      err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          app_q     <= append_i;
          app_off_q <= app_off_i;
          app_id_q  <= app_id_i;
          app_ver_q <= app_ver_i;
          cur_q     <= BASE_L;
          back_q    <= '0;
          sid_q     <= append_i ? '1 : sid_i;  // never-match ID finds the tail
          if (append_i && app_bad) begin
            done_q <= 1'b1; err_q <= 1'b1; found_q <= 1'b0;
            res_q <= '0; prev_q <= '0;
          end else if (append_i && app_off_i == BASE_L) begin
            st_q <= S_NEW;
          end else begin
            st_q <= S_RD;
          end
        end
        S_RD: st_q <= S_CHK;
        S_CHK: begin
          hdr_q <= rhdr;
          if (cur_q == BASE_L && blank) begin
            st_q <= S_IDLE; done_q <= 1'b1; found_q <= 1'b0;
            err_q <= app_q; res_q <= '0; prev_q <= '0;
          end else if (hit) begin
            st_q <= S_IDLE; done_q <= 1'b1; found_q <= 1'b1;
            err_q <= 1'b0; res_q <= cur_q; prev_q <= back_q;
          end else if (tail) begin
            if (app_q) begin
              st_q <= S_PATCH; back_q <= cur_q;
            end else begin
              st_q <= S_IDLE; done_q <= 1'b1; found_q <= 1'b0;
              err_q <= 1'b0; res_q <= '0; prev_q <= cur_q;
            end
          end else if (ptr_bad || g_last) begin
            st_q <= S_IDLE; done_q <= 1'b1; found_q <= 1'b0;
            err_q <= 1'b1; res_q <= '0; prev_q <= '0;
          end else begin
            back_q <= cur_q;
            cur_q  <= rhdr.nxt;
            st_q   <= S_RD;
          end
        end
        S_PATCH: st_q <= S_NEW;
        S_NEW: begin
          st_q <= S_IDLE; done_q <= 1'b1; found_q <= 1'b0;
          err_q <= 1'b0; res_q <= '0; prev_q <= back_q;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_wdata_o = {NXT_W'(0), app_ver_q, app_id_q};
    if (st_q == S_PATCH) mem_wdata_o = {app_off_q, hdr_q.ver, hdr_q.id};
  end

  assign mem_re_o   = (st_q == S_RD);
  assign mem_we_o   = (st_q == S_PATCH) || (st_q == S_NEW);
  assign mem_addr_o = (st_q == S_NEW) ? app_off_q : cur_q;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
  assign found_o    = found_q;
  assign err_o      = err_q;
  assign next_o     = res_q;
  assign prev_o     = prev_q;

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o || done_o));
  p_found_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && found_o) |-> (next_o >= BASE_L && next_o[1:0] == 2'b00));
  p_err_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (!found_o && next_o == '0));
  p_rw_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  p_read_then_chk_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);
  p_we_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
endmodule

// File: tb/ecap_walker_test.sv
`timescale 1ns/1ps
module ecap_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, append = 1'b0;
  logic [16:0] sid = '0;
  logic [11:0] app_off = '0;
  logic [12:0] app_size = '0;
  logic [15:0] app_id = '0;
  logic [3:0]  app_ver = '0;
  logic        busy, done, found, err, mem_re, mem_we;
  logic [11:0] next_off, prev_off, mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [31:0] mem [1024];
  int          checks = 0, errors = 0, wr_cnt = 0;

  always #2.5 clk = ~clk;

  ecap_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .append_i(append),
    .sid_i(sid), .app_off_i(app_off), .app_size_i(app_size),
    .app_id_i(app_id), .app_ver_i(app_ver), .busy_o(busy), .done_o(done),
    .found_o(found), .err_o(err), .next_o(next_off), .prev_o(prev_off),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_we) begin
      mem[mem_addr[11:2]] <= mem_wdata;
      wr_cnt = wr_cnt + 1;
    end
  end

  function automatic logic [31:0] hdr(input logic [15:0] id, input logic [3:0] ver,
                                      input logic [11:0] nxt);
    return {nxt, ver, id};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic base_list();
    clear_mem();
    mem[12'h100 >> 2] = hdr(16'h0001, 4'h1, 12'h140);
    mem[12'h140 >> 2] = hdr(16'h000E, 4'h2, 12'h200);
    mem[12'h200 >> 2] = hdr(16'h0003, 4'h1, 12'h000);
  endtask

  task automatic run(input logic op, input logic [16:0] s, input logic [11:0] off,
                     input logic [12:0] sz, input logic [15:0] id, input logic [3:0] ver);
    int n;
    @(negedge clk);
    append = op; sid = s; app_off = off; app_size = sz; app_id = id; app_ver = ver;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk("R2 done timeout", 32'd0, 32'd1);
  endtask

  // {sid, found, next, prev}
  localparam logic [41:0] VEC [6] = '{
    {17'h00001, 1'b1, 12'h100, 12'h000},
    {17'h0000E, 1'b1, 12'h140, 12'h100},
    {17'h00003, 1'b1, 12'h200, 12'h140},
    {17'h00007, 1'b0, 12'h000, 12'h200},
    {17'h1FFFF, 1'b0, 12'h000, 12'h200},
    {17'h10001, 1'b0, 12'h000, 12'h200}
  };

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset busy/done/found/err", {busy, done, found, err}, 4'b0000);
    chk("R1 reset mem strobes", {mem_re, mem_we}, 2'b00);

    // R3 R5 R6 R12: table of searches over a three-element chain
    base_list();
    for (int i = 0; i < 6; i++) begin
      run(1'b0, VEC[i][41:25], '0, '0, '0, '0);
      chk($sformatf("R5/R6 vec%0d found", i), found, VEC[i][24]);
      chk($sformatf("R5/R6 vec%0d next", i), next_off, VEC[i][23:12]);
      chk($sformatf("R6 vec%0d prev", i), prev_off, VEC[i][11:0]);
      chk($sformatf("R7 vec%0d err", i), err, 1'b0);
    end

    // R2 done single pulse, results held
    @(negedge clk);
    chk("R2 done pulse width", done, 1'b0);
    chk("R2 prev held", prev_off, 12'h200);

    // R4 empty chain, ID 0 coinciding with blank head
    clear_mem();
    run(1'b0, 17'h00000, '0, '0, '0, '0);
    chk("R4 empty found/err", {found, err}, 2'b00);
    chk("R4 empty next/prev", {next_off, prev_off}, 24'h0);

    // R7 bad pointers
    clear_mem(); mem[12'h100 >> 2] = hdr(16'h0001, 4'h1, 12'h142);
    run(1'b0, 17'h5, '0, '0, '0, '0);
    chk("R7 misaligned err", {err, found}, 2'b10);
    mem[12'h100 >> 2] = hdr(16'h0001, 4'h1, 12'h080);
    run(1'b0, 17'h5, '0, '0, '0, '0);
    chk("R7 below base err", err, 1'b1);
    mem[12'h100 >> 2] = hdr(16'h0001, 4'h1, 12'hFFC);
    run(1'b0, 17'h5, '0, '0, '0, '0);
    chk("R7 above limit err", {err, next_off}, {1'b1, 12'h000});

    // R8 cyclic chain
    mem[12'h100 >> 2] = hdr(16'h0001, 4'h1, 12'h100);
    run(1'b0, 17'h5, '0, '0, '0, '0);
    chk("R8 cycle guard err", {err, found}, 2'b10);

    // R9 append at head
    clear_mem();
    w0 = wr_cnt;
    run(1'b1, '0, 12'h100, 13'h020, 16'h0ABC, 4'h2);
    chk("R9 head append err", err, 1'b0);
    chk("R9 head header", mem[12'h100 >> 2], 32'h0002_0ABC);
    chk("R9 one write", wr_cnt - w0, 1);

    // R10 append at tail
    base_list();
    w0 = wr_cnt;
    run(1'b1, '0, 12'h300, 13'h010, 16'h0019, 4'h1);
    chk("R10 append err", err, 1'b0);
    chk("R10 tail patched", mem[12'h200 >> 2], hdr(16'h0003, 4'h1, 12'h300));
    chk("R10 new header", mem[12'h300 >> 2], hdr(16'h0019, 4'h1, 12'h000));
    chk("R10 prev old tail", prev_off, 12'h200);
    chk("R10 two writes", wr_cnt - w0, 2);
    run(1'b0, 17'h00019, '0, '0, '0, '0);
    chk("R10 search new", {found, next_off, prev_off}, {1'b1, 12'h300, 12'h200});

    // R11 boundary: ends exactly at 0x1000
    w0 = wr_cnt;
    run(1'b1, '0, 12'hFF0, 13'h010, 16'h0022, 4'h3);
    chk("R11 exact fit ok", {err, 5'(wr_cnt - w0)}, {1'b0, 5'd2});
    chk("R11 exact fit header", mem[12'hFF0 >> 2], hdr(16'h0022, 4'h3, 12'h000));

    // R11 bad append parameters write nothing
    w0 = wr_cnt;
    run(1'b1, '0, 12'h400, 13'h004, 16'h0023, 4'h1);
    chk("R11 small size err", err, 1'b1);
    run(1'b1, '0, 12'hFF8, 13'h010, 16'h0023, 4'h1);
    chk("R11 past end err", err, 1'b1);
    run(1'b1, '0, 12'h0C0, 13'h010, 16'h0023, 4'h1);
    chk("R11 below base err", err, 1'b1);
    run(1'b1, '0, 12'h402, 13'h010, 16'h0023, 4'h1);
    chk("R11 misaligned err", err, 1'b1);
    chk("R11 no writes", wr_cnt - w0, 0);

    // R10 append beyond head into empty chain
    clear_mem();
    w0 = wr_cnt;
    run(1'b1, '0, 12'h300, 13'h010, 16'h0019, 4'h1);
    chk("R10 empty chain err", err, 1'b1);
    chk("R10 empty chain no write", wr_cnt - w0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule